// File: doc/BRIEF.md
# Replica Delay Edge Monitor Controller

This block is the digital half of a closed-loop supply controller that uses a tunable replica of the chip's slowest path. A tap register picks the point of a configurable delay chain whose delay best matches the real critical path; the tap is written during production test and then frozen by a lock input. While running, the block repeats a fixed measurement: it raises a launch signal for exactly one clock cycle and, on the clock edge that ends that cycle, samples the outputs of a buffer string that follows the chosen tap. The sampled word is read as a thermometer code whose run of ones from bit 0 tells how far the edge travelled in one cycle.

The edge position is compared with a programmable target stage and guard band. Too short a run asks the external regulator to raise the supply, a run well past the target plus guard asks for a lower supply, and anything in between holds. A captured word that is not a clean thermometer code sets a sticky flag and is treated as a timing risk, so it asks for a raise. Step requests are one-cycle pulses and are allowed on only every Nth measurement so the regulator can settle; from reset until the first clean measurement, the raise request is held high.

Top module: `replica_edge_monitor`

## Requirements
- R1: While the tap is unlocked, a cycle with `tap_we` high loads `tap_wdata` into `tap_sel`, visible from the following cycle; reset clears `tap_sel` to 0.
- R2: After a cycle with `tap_lock` high, `tap_locked` reads 1 and `tap_sel` no longer changes on writes until reset.
- R3: With `run` high, measurements repeat every 4 cycles and `launch` is high for exactly one cycle per measurement; with `run` low, the measurement in progress finishes and `launch` then stays low.
- R4: `buf_vec` is sampled on the edge that ends the launch cycle; three cycles later `meas_done` pulses for one cycle and `edge_pos` shows the number of consecutive ones in `buf_vec` counted upward from bit 0 (0 to 16).
- R5: A sampled word holding any 1 above its leading run of ones sets `bubble_flag`, which stays set until reset.
- R6: A measurement with such a non-thermometer word requests a raise at a decision point, never a lowering.
- R7: A clean measurement with `edge_pos` below `target` gives a one-cycle `step_up` pulse together with `meas_done` at a decision point.
- R8: A clean measurement with `edge_pos` greater than `target + guard` gives a one-cycle `step_dn` pulse at a decision point; a position from `target` to `target + guard` inclusive gives neither.
- R9: Decision points are the 1st, (N+1)th, (2N+1)th ... measurements after reset, N being `interval` with 0 treated as 1; other measurements give no step pulse.
- R10: From reset until the first measurement without a bubble completes, `step_up` is held high on every cycle.
- R11: `step_up` and `step_dn` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep measuring while high |
| tap_we | input | 1 | Write strobe for the tap register |
| tap_wdata | input | TAPW (3) | Tap index to load |
| tap_lock | input | 1 | Freeze the tap register until reset |
| target | input | POSW (5) | Buffer stage the edge should reach |
| guard | input | POSW (5) | Extra stages allowed before lowering |
| interval | input | IVW (8) | Measurements per decision (0 acts as 1) |
| buf_vec | input | NBUF (16) | Buffer string outputs, bit 0 nearest the tap |
| tap_sel | output | TAPW (3) | Selected delay chain tap |
| tap_locked | output | 1 | Tap register is frozen |
| launch | output | 1 | Launch edge into the replica chain |
| meas_done | output | 1 | One-cycle pulse when a result is posted |
| edge_pos | output | POSW (5) | Last measured edge position |
| bubble_flag | output | 1 | Sticky non-thermometer capture seen |
| step_up | output | 1 | Raise-supply request |
| step_dn | output | 1 | Lower-supply request |

## Verification
The assertions watch, on every cycle, that the two step requests never overlap, that launch never lasts two cycles, that every posted result sits three cycles after a launch, that a lowering only comes with a result, that the bubble flag never clears by itself and that a locked tap never moves. Whether the edge position is decoded correctly, whether the raise, hold and lower choices fall on the right side of the target and guard bounds, the spacing of decision points for several intervals, and the held raise before the first clean result can only be shown by the bench's scenarios against its cycle model.

// File: rtl/rem_pkg.sv
package rem_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PRIME  = 3'd1,
    S_LAUNCH = 3'd2,
    S_DECODE = 3'd3,
    S_DECIDE = 3'd4
  } seq_t;

  typedef enum logic [1:0] {
    V_HOLD = 2'd0,
    V_UP   = 2'd1,
    V_DN   = 2'd2
  } vote_t;
endpackage

// File: rtl/rem_tap_reg.sv
module rem_tap_reg #(
  parameter int TAPW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [TAPW-1:0] wr_val,
  input  logic            lock_req,
  output logic [TAPW-1:0] tap_q,
  output logic            locked_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_en && !locked_q) tap_q <= wr_val;
      if (lock_req) locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rem_seq.sv
module rem_seq
  import rem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic launch_q,
  output logic cap_en,
  output logic dec_en,
  output logic decide_en
);
  seq_t st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      S_IDLE:   st_n = run ? S_PRIME : S_IDLE;
      S_PRIME:  st_n = S_LAUNCH;
      S_LAUNCH: st_n = S_DECODE;
      S_DECODE: st_n = S_DECIDE;
      S_DECIDE: st_n = run ? S_PRIME : S_IDLE;
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      launch_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      launch_q <= (st_n == S_LAUNCH);
    end
  end

  assign cap_en    = (st_q == S_LAUNCH);
  assign dec_en    = (st_q == S_DECODE);
  assign decide_en = (st_q == S_DECIDE);
endmodule

// File: rtl/rem_therm.sv
module rem_therm #(
  parameter int NBUF = 16,
  parameter int POSW = $clog2(NBUF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            dec_en,
  input  logic [NBUF-1:0] vec_in,
  output logic [POSW-1:0] pos_q,
  output logic            bub_q
);
  logic [NBUF-1:0] cap_q;
  logic [NBUF-1:0] run_mask;

  assign run_mask[0] = cap_q[0];
  for (genvar i = 1; i < NBUF; i++) begin : g_prefix
    assign run_mask[i] = run_mask[i-1] & cap_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= vec_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      bub_q <= 1'b0;
    end else if (dec_en) begin
      pos_q <= POSW'($countones(run_mask));
      bub_q <= |(cap_q & ~run_mask);
    end
  end
endmodule

// File: rtl/rem_step.sv
module rem_step
  import rem_pkg::*;
#(
  parameter int POSW = 5,
  parameter int IVW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            decide_en,
  input  logic [POSW-1:0] pos,
  input  logic            bub,
  input  logic [POSW-1:0] target,
  input  logic [POSW-1:0] guard,
  input  logic [IVW-1:0]  interval,
  output logic            step_up,
  output logic            step_dn,
  output logic            meas_done,
  output logic [POSW-1:0] edge_pos,
  output logic            bubble_flag
);
  logic [IVW-1:0] cnt_q;
  logic [IVW:0]   ivl_eff;
  logic [IVW:0]   cnt_inc;
  logic [POSW:0]  hi_lim;
  logic           primed_q;
  logic           issue;
  vote_t          vote;

  assign ivl_eff = (interval == '0) ? (IVW+1)'(1) : {1'b0, interval};
  assign cnt_inc = {1'b0, cnt_q} + (IVW+1)'(1);
  assign hi_lim  = {1'b0, target} + {1'b0, guard};
  assign issue   = (cnt_q == '0);

  always_comb begin
    vote = V_HOLD;
    if (bub) begin
      vote = V_UP;
    end else if (pos < target) begin
      vote = V_UP;
    end else if ({1'b0, pos} > hi_lim) begin
      vote = V_DN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      primed_q    <= 1'b0;
      step_up     <= 1'b1;
      step_dn     <= 1'b0;
      meas_done   <= 1'b0;
      edge_pos    <= '0;
      bubble_flag <= 1'b0;
    end else if (decide_en) begin
      meas_done <= 1'b1;
      edge_pos  <= pos;
      cnt_q     <= (cnt_inc >= ivl_eff) ? '0 : cnt_inc[IVW-1:0];
      if (bub) begin
        bubble_flag <= 1'b1;
        step_up     <= issue || !primed_q;
        step_dn     <= 1'b0;
      end else begin
        primed_q <= 1'b1;
        step_up  <= issue && (vote == V_UP);
        step_dn  <= issue && (vote == V_DN);
      end
    end else begin
      meas_done <= 1'b0;
      step_up   <= !primed_q;
      step_dn   <= 1'b0;
    end
  end
endmodule

// File: rtl/replica_edge_monitor.sv
module replica_edge_monitor #(
  parameter int NTAP = 8,
  parameter int NBUF = 16,
  parameter int IVW  = 8,
  localparam int TAPW = $clog2(NTAP),
  localparam int POSW = $clog2(NBUF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tap_we,
  input  logic [TAPW-1:0] tap_wdata,
  input  logic            tap_lock,
  input  logic [POSW-1:0] target,
  input  logic [POSW-1:0] guard,
  input  logic [IVW-1:0]  interval,
  input  logic [NBUF-1:0] buf_vec,
  output logic [TAPW-1:0] tap_sel,
  output logic            tap_locked,
  output logic            launch,
  output logic            meas_done,
  output logic [POSW-1:0] edge_pos,
  output logic            bubble_flag,
  output logic            step_up,
  output logic            step_dn
);
  logic            cap_en;
  logic            dec_en;
  logic            decide_en;
  logic [POSW-1:0] pos_w;
  logic            bub_w;

  rem_tap_reg #(.TAPW(TAPW)) u_tap (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tap_we),
    .wr_val   (tap_wdata),
    .lock_req (tap_lock),
    .tap_q    (tap_sel),
    .locked_q (tap_locked)
  );

  rem_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .launch_q  (launch),
    .cap_en    (cap_en),
    .dec_en    (dec_en),
    .decide_en (decide_en)
  );

  rem_therm #(.NBUF(NBUF), .POSW(POSW)) u_therm (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .dec_en (dec_en),
    .vec_in (buf_vec),
    .pos_q  (pos_w),
    .bub_q  (bub_w)
  );

  rem_step #(.POSW(POSW), .IVW(IVW)) u_step (
    .clk         (clk),
    .rst         (rst),
    .decide_en   (decide_en),
    .pos         (pos_w),
    .bub         (bub_w),
    .target      (target),
    .guard       (guard),
    .interval    (interval),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .meas_done   (meas_done),
    .edge_pos    (edge_pos),
    .bubble_flag (bubble_flag)
  );
endmodule

// File: rtl/rem_checker.sv
module rem_checker #(
  parameter int TAPW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [TAPW-1:0] tap_sel,
  input logic            tap_locked,
  input logic            launch,
  input logic            meas_done,
  input logic            bubble_flag,
  input logic            step_up,
  input logic            step_dn
);
  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn));                                   // R11
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);                                      // R3
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    tap_locked |=> $stable(tap_sel) && tap_locked);           // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    bubble_flag |=> bubble_flag);                             // R5
  AST_DONE_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    meas_done |-> $past(launch, 3));                          // R4
  AST_DN_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    step_dn |-> meas_done);                                   // R8
endmodule

bind replica_edge_monitor rem_checker #(.TAPW(TAPW)) u_rem_checker (
  .clk         (clk),
  .rst         (rst),
  .tap_sel     (tap_sel),
  .tap_locked  (tap_locked),
  .launch      (launch),
  .meas_done   (meas_done),
  .bubble_flag (bubble_flag),
  .step_up     (step_up),
  .step_dn     (step_dn)
);

// File: tb/replica_edge_monitor_bench.sv
module replica_edge_monitor_bench;
  localparam int TAPW = 3;
  localparam int POSW = 5;
  localparam int IVW  = 8;
  localparam int NBUF = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            run = 1'b0;
  logic            tap_we = 1'b0;
  logic [TAPW-1:0] tap_wdata = '0;
  logic            tap_lock = 1'b0;
  logic [POSW-1:0] target = 5'd8;
  logic [POSW-1:0] guard = 5'd2;
  logic [IVW-1:0]  interval = 8'd1;
  logic [NBUF-1:0] pat = '0;
  logic [NBUF-1:0] buf_vec;
  logic [TAPW-1:0] tap_sel;
  logic            tap_locked, launch, meas_done, bubble_flag, step_up, step_dn;
  logic [POSW-1:0] edge_pos;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  // replica chain stand-in: the edge reaches the pattern only while launched
  always_comb buf_vec = launch ? pat : '0;

  replica_edge_monitor u_replica_edge_monitor (
    .clk(clk), .rst(rst), .run(run), .tap_we(tap_we), .tap_wdata(tap_wdata),
    .tap_lock(tap_lock), .target(target), .guard(guard), .interval(interval),
    .buf_vec(buf_vec), .tap_sel(tap_sel), .tap_locked(tap_locked),
    .launch(launch), .meas_done(meas_done), .edge_pos(edge_pos),
    .bubble_flag(bubble_flag), .step_up(step_up), .step_dn(step_dn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lead_ones(input logic [NBUF-1:0] v);
    int n = 0;
    while (n < NBUF && v[n]) n++;
    return n;
  endfunction

  // behavioural cycle model
  int m_ph, m_pos, m_cnt, m_edge, m_tap, m_ivl;
  bit m_launch, m_bub, m_primed, m_up, m_dn, m_done, m_flag, m_lock, m_issue;
  logic [NBUF-1:0] m_cap;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_launch = 0; m_cap = '0; m_pos = 0; m_bub = 0; m_cnt = 0;
      m_primed = 0; m_up = 1; m_dn = 0; m_edge = 0; m_flag = 0; m_done = 0;
      m_tap = 0; m_lock = 0;
    end else begin
      if (tap_we && !m_lock) m_tap = int'(tap_wdata);
      if (tap_lock) m_lock = 1;
      m_done = 0; m_dn = 0; m_up = !m_primed;
      if (m_ph == 4) begin
        m_issue = (m_cnt == 0);
        m_done = 1; m_edge = m_pos;
        if (m_bub) begin
          m_flag = 1; m_up = m_issue || !m_primed;
        end else begin
          m_primed = 1;
          m_up = m_issue && (m_pos < int'(target));
          m_dn = m_issue && (m_pos > int'(target) + int'(guard));
        end
        m_ivl = (interval == 0) ? 1 : int'(interval);
        m_cnt = (m_cnt + 1 >= m_ivl) ? 0 : m_cnt + 1;
      end
      if (m_ph == 3) begin
        m_pos = lead_ones(m_cap);
        m_bub = (32'(m_cap) != ((32'd1 << m_pos) - 32'd1));
      end
      if (m_ph == 2) m_cap = buf_vec;
      case (m_ph)
        0: m_ph = run ? 1 : 0;
        4: m_ph = run ? 1 : 0;
        default: m_ph = m_ph + 1;
      endcase
      m_launch = (m_ph == 2);
    end
  end

  always @(negedge clk) begin
    chk(tap_sel == TAPW'(m_tap), "R1 tap_sel", int'(tap_sel), m_tap);
    chk(tap_locked == m_lock, "R2 tap_locked", int'(tap_locked), int'(m_lock));
    chk(launch == m_launch, "R3 launch", int'(launch), int'(m_launch));
    chk(meas_done == m_done, "R4 meas_done", int'(meas_done), int'(m_done));
    chk(int'(edge_pos) == m_edge, "R4 edge_pos", int'(edge_pos), m_edge);
    chk(bubble_flag == m_flag, "R5 bubble_flag", int'(bubble_flag), int'(m_flag));
    chk(step_up == m_up, "R7 step_up", int'(step_up), int'(m_up));
    chk(step_dn == m_dn, "R8 step_dn", int'(step_dn), int'(m_dn));
    chk(!(step_up && step_dn), "R11 exclusive", int'({step_up, step_dn}), 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // vote: 0 hold, 1 raise, 2 lower
  task automatic meas(input logic [NBUF-1:0] p, input int exp_pos, input int vote,
                      input string tag);
    pat = p;
    do @(negedge clk); while (!meas_done);
    chk(int'(edge_pos) == exp_pos, {tag, " edge_pos"}, int'(edge_pos), exp_pos);
    chk(step_up == (vote == 1), {tag, " step_up"}, int'(step_up), int'(vote == 1));
    chk(step_dn == (vote == 2), {tag, " step_dn"}, int'(step_dn), int'(vote == 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(step_up == 1'b1, "R10 raise after reset", int'(step_up), 1);
    chk(tap_sel == '0, "R1 tap reset", int'(tap_sel), 0);
    chk(bubble_flag == 1'b0, "R5 flag reset", int'(bubble_flag), 0);

    tap_we = 1; tap_wdata = 3'd5; @(negedge clk); tap_we = 0;
    chk(tap_sel == 3'd5, "R1 tap write", int'(tap_sel), 5);
    tap_we = 1; tap_wdata = 3'd3; @(negedge clk); tap_we = 0;
    chk(tap_sel == 3'd3, "R1 tap rewrite", int'(tap_sel), 3);
    tap_lock = 1; @(negedge clk); tap_lock = 0;
    tap_we = 1; tap_wdata = 3'd1; @(negedge clk); tap_we = 0;
    @(negedge clk);
    chk(tap_sel == 3'd3 && tap_locked, "R2 locked write ignored", int'(tap_sel), 3);

    target = 5'd8; guard = 5'd2; interval = 8'd1;
    pat = 16'h0005;
    run = 1;
    repeat (3) @(negedge clk);
    chk(step_up == 1'b1, "R10 raise held before result", int'(step_up), 1);
    meas(16'h0005, 1, 1, "R6 bubble raises");
    chk(bubble_flag == 1'b1, "R5 flag set", int'(bubble_flag), 1);
    @(negedge clk);
    chk(step_up == 1'b1, "R10 raise held after bubble", int'(step_up), 1);
    meas(16'h03FF, 10, 0, "R8 top of band holds");
    @(negedge clk);
    chk(step_up == 1'b0, "R10 released after clean result", int'(step_up), 0);
    meas(16'h0007, 3, 1, "R7 short raises");
    meas(16'h0FFF, 12, 2, "R8 long lowers");
    meas(16'h00FF, 8, 0, "R8 at target holds");
    meas(16'h07FF, 11, 2, "R8 just past band lowers");
    meas(16'h007F, 7, 1, "R7 one short raises");
    meas(16'hFFFF, 16, 2, "R4 full run");
    meas(16'h0000, 0, 1, "R4 empty run");
    chk(bubble_flag == 1'b1, "R5 flag stays", int'(bubble_flag), 1);

    interval = 8'd3;
    meas(16'h0007, 3, 1, "R9 first of three decides");
    meas(16'h0007, 3, 0, "R9 second skipped");
    meas(16'h0007, 3, 0, "R9 third skipped");
    meas(16'h0007, 3, 1, "R9 fourth decides");
    meas(16'h0FFF, 12, 0, "R9 fifth skipped");
    meas(16'h00F3, 2, 0, "R9 bubble off decision");
    interval = 8'd0;
    meas(16'h0FFF, 12, 2, "R9 zero acts as one");
    meas(16'h0001, 1, 1, "R9 zero acts as one again");

    run = 0;
    repeat (6) @(negedge clk);
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        if (launch) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R3 stopped no launch", seen, 0);
    end

    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
    chk(bubble_flag == 1'b0, "R5 cleared by reset", int'(bubble_flag), 1'b0);
    chk(!tap_locked && tap_sel == '0, "R2 unlocked by reset", int'(tap_locked), 0);
    tap_we = 1; tap_wdata = 3'd6; @(negedge clk); tap_we = 0;
    chk(tap_sel == 3'd6, "R1 write after reset", int'(tap_sel), 6);

    interval = 8'd2;
    run = 1;
    meas(16'h01FF, 9, 0, "R8 clean first result holds");
    meas(16'h0003, 2, 0, "R9 off-decision short holds");
    meas(16'h0003, 2, 1, "R7 decision raise");
    run = 0;
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule